// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Chopping Timer

This block sequences the off-time of a current-chopping loop that drives a full-bridge motor stage. While the bridge conducts, the block waits for the current-sense comparator to trip. A trip starts an off interval of fixed, programmable length. The interval is measured in ticks of a reference oscillator, which arrive as a one-cycle enable pulse in the system clock domain.

During the off interval the block tells the bridge logic which recirculation style to use. In mixed mode the interval opens with a fast-decay portion of programmable length, and slow decay covers the rest. In slow mode the whole interval is slow decay. When the interval ends, the bridge returns to conduction and the comparator is accepted again. A synchronous disable forces the timer back to its idle, conducting state and clears its counters.

Top module: `chop_offtime_timer`

## Requirements
- R1: After reset, `phase_on_o` is 1 and `phase_fast_o` and `phase_slow_o` are 0.
- R2: When `trip_i` is 1 at a clock edge while `phase_on_o` is 1 and `halt_i` is 0, `phase_on_o` is 0 from the next cycle on.
- R3: The off interval lasts L ticks, where L = `toff_i` and a value of 0 gives L = 1. The block returns to the on phase in the cycle after the clock edge that carries the L-th tick after the trip edge. A tick that falls on the trip edge itself does not count.
- R4: In mixed mode (`slow_mode_i` = 0), the first F ticks of the interval are fast decay, where F = `tfast_i`, and the rest of the interval is slow decay. Once slow decay begins, fast decay does not return within that interval.
- R5: In mixed mode, if F >= L the whole interval is fast decay, and if F = 0 the whole interval is slow decay.
- R6: In slow mode (`slow_mode_i` = 1), the whole off interval is slow decay, whatever the value of `tfast_i`.
- R7: A trip that arrives while the off interval runs has no effect on the phase outputs or on the length of the interval.
- R8: The interval counter advances only on clock edges where `tick_i` is 1. Without ticks, the phase outputs hold their values.
- R9: `toff_i`, `tfast_i` and `slow_mode_i` are captured at the trip edge. Changes to them during the interval have no effect until the next trip.
- R10: While `halt_i` is 1 at a clock edge, the block goes to the on phase with cleared counters from the next cycle, and it ignores any trip at that edge. Halt takes priority over a trip at the same edge.
- R11: Exactly one of the three phase outputs is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Synchronous disable; forces the idle on phase |
| tick_i | input | 1 | One-cycle oscillator tick enable |
| trip_i | input | 1 | Current-sense comparator trip |
| slow_mode_i | input | 1 | Decay select: 0 = mixed, 1 = slow |
| toff_i | input | 5 | Off-interval length in ticks (0 means 1) |
| tfast_i | input | 4 | Fast-decay portion in ticks |
| phase_on_o | output | 1 | Bridge conducts |
| phase_fast_o | output | 1 | Off interval, fast decay |
| phase_slow_o | output | 1 | Off interval, slow decay |

## Verification
Several functions can fall on the same clock edge. A tick can coincide with the trip edge, and the bench runs a one-cycle tick period so that this happens all the time. By R3, a tick on the trip edge must not shorten the interval. The expiring tick can also coincide with a trip that is held high: the per-cycle model accepts the re-trip only one edge after the return to the on phase. Halt is also raised in the same cycle as a trip, and the model expects the on phase to persist.

// File: rtl/chop_offtime_timer.sv
module chop_offtime_timer #(
  parameter int OFF_W  = 5,
  parameter int FAST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              tick_i,
  input  logic              trip_i,
  input  logic              slow_mode_i,
  input  logic [OFF_W-1:0]  toff_i,
  input  logic [FAST_W-1:0] tfast_i,
  output logic              phase_on_o,
  output logic              phase_fast_o,
  output logic              phase_slow_o
);

  localparam int CW = (OFF_W > FAST_W) ? OFF_W : FAST_W;

  logic              off_q;
  logic [OFF_W-1:0]  elapsed_q;
  logic [OFF_W-1:0]  last_q;
  logic [FAST_W-1:0] fast_q;
  logic              slow_q;

  logic              start;
  logic              expire;
  logic [OFF_W-1:0]  last_d;

  assign start  = !off_q && trip_i && !halt_i;
  assign last_d = (toff_i == '0) ? '0 : toff_i - 1'b1;
  assign expire = off_q && tick_i && (elapsed_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q     <= 1'b0;
      elapsed_q <= '0;
      last_q    <= '0;
      fast_q    <= '0;
      slow_q    <= 1'b0;
    end else if (halt_i) begin
      off_q     <= 1'b0;
      elapsed_q <= '0;
      last_q    <= '0;
      fast_q    <= '0;
      slow_q    <= 1'b0;
    end else if (start) begin
      off_q     <= 1'b1;
      elapsed_q <= '0;
      last_q    <= last_d;
      fast_q    <= tfast_i;
      slow_q    <= slow_mode_i;
    end else if (expire) begin
      off_q     <= 1'b0;
      elapsed_q <= '0;
    end else if (off_q && tick_i) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  logic in_fast;
  assign in_fast = CW'(elapsed_q) < CW'(fast_q);

  assign phase_on_o   = !off_q;
  assign phase_fast_o = off_q && !slow_q && in_fast;
  assign phase_slow_o = off_q && !(!slow_q && in_fast);

  p_onehot_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({phase_on_o, phase_fast_o, phase_slow_o}));

  p_trip_leaves_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_on_o && trip_i && !halt_i) |=> !phase_on_o);

  p_no_tick_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_on_o && !tick_i && !halt_i) |=>
      ($stable(phase_on_o) && $stable(phase_fast_o) && $stable(phase_slow_o)));

  p_halt_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> phase_on_o);

  p_no_fast_after_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_slow_o |=> !phase_fast_o);

  p_slow_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && slow_q) |-> !phase_fast_o);

endmodule

// File: tb/test_chop_offtime_timer.sv
`timescale 1ns/1ps
module test_chop_offtime_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt = 1'b0, tick = 1'b0, trip = 1'b0, smode = 1'b0;
  logic [4:0] toff = 5'd0;
  logic [3:0] tfast = 4'd0;
  logic on_o, fast_o, slow_o;

  always #2.5 clk = ~clk;

  chop_offtime_timer i_chop_offtime_timer (
    .clk(clk), .rst_n(rst_n), .halt_i(halt), .tick_i(tick), .trip_i(trip),
    .slow_mode_i(smode), .toff_i(toff), .tfast_i(tfast),
    .phase_on_o(on_o), .phase_fast_o(fast_o), .phase_slow_o(slow_o));

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";
  int tick_div = 0;
  int tick_cnt = 0;

  // behavioural reference
  int m_on = 1, m_el = 0, m_len = 1, m_fast = 0, m_slow = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 1; m_el = 0;
    end else if (halt) begin
      m_on = 1; m_el = 0;
    end else if (m_on == 1) begin
      if (trip) begin
        m_on = 0; m_el = 0;
        m_len = (toff == 0) ? 1 : int'(toff);
        m_fast = int'(tfast); m_slow = int'(smode);
      end
    end else if (tick) begin
      if (m_el + 1 >= m_len) begin m_on = 1; m_el = 0; end
      else m_el = m_el + 1;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      logic e_on, e_fast, e_slow;
      e_on   = (m_on == 1);
      e_fast = !e_on && (m_slow == 0) && (m_el < m_fast);
      e_slow = !e_on && !e_fast;
      check(cur_req, on_o, e_on, "on");
      check(cur_req, fast_o, e_fast, "fast");
      check(cur_req, slow_o, e_slow, "slow");
      check("R11", 1'(($countones({on_o, fast_o, slow_o})) == 1), 1'b1, "onehot");
    end
    if (tick_div > 0) begin
      tick_cnt = (tick_cnt + 1) % tick_div;
      tick <= (tick_cnt == 0);
    end else tick <= 1'b0;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trip();
    trip = 1'b1; cyc(1); trip = 1'b0;
  endtask

  task automatic setup(input int off, input int fst, input logic sm, input int div);
    toff = 5'(off); tfast = 4'(fst); smode = sm; tick_div = div;
  endtask

  initial begin
    cyc(3);
    cur_req = "R1";
    check("R1", on_o, 1'b1, "reset on");
    check("R1", fast_o, 1'b0, "reset fast");
    check("R1", slow_o, 1'b0, "reset slow");
    rst_n = 1'b1;
    cyc(4);

    cur_req = "R2"; setup(4, 2, 1'b0, 3);
    pulse_trip();
    check("R2", on_o, 1'b0, "on dropped after trip");
    check("R4", fast_o, 1'b1, "mixed starts fast");
    cyc(20);

    cur_req = "R3"; setup(0, 0, 1'b1, 1);
    pulse_trip(); cyc(6);
    setup(31, 0, 1'b1, 1); pulse_trip(); cyc(40);
    setup(7, 2, 1'b0, 2); pulse_trip(); cyc(25);

    cur_req = "R4"; setup(10, 3, 1'b0, 2);
    pulse_trip(); cyc(30);

    cur_req = "R5"; setup(6, 15, 1'b0, 2);
    pulse_trip(); cyc(20);
    setup(6, 6, 1'b0, 1); pulse_trip(); cyc(12);
    setup(6, 0, 1'b0, 2); pulse_trip();
    check("R5", slow_o, 1'b1, "fast zero gives slow");
    cyc(20);

    cur_req = "R6"; setup(8, 9, 1'b1, 2);
    pulse_trip();
    check("R6", fast_o, 1'b0, "slow mode no fast");
    cyc(25);

    cur_req = "R7"; setup(5, 2, 1'b0, 2);
    trip = 1'b1; cyc(60); trip = 1'b0; cyc(15);

    cur_req = "R8"; setup(6, 3, 1'b0, 2);
    pulse_trip(); cyc(3); tick_div = 0; cyc(30);
    check("R8", on_o, 1'b0, "held without ticks");
    tick_div = 2; cyc(20);

    cur_req = "R9"; setup(9, 4, 1'b0, 2);
    pulse_trip(); cyc(2);
    setup(1, 0, 1'b1, 2); cyc(30);

    cur_req = "R10"; setup(20, 5, 1'b0, 2);
    pulse_trip(); cyc(5);
    halt = 1'b1; cyc(1);
    check("R10", on_o, 1'b1, "halt returns on");
    trip = 1'b1; cyc(3);
    check("R10", on_o, 1'b1, "halt beats trip");
    halt = 1'b0; cyc(1); trip = 1'b0;
    check("R10", on_o, 1'b0, "trip after halt release");
    cyc(50);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule